// File: doc/BRIEF.md
# Packed Saturating Integer Add/Subtract Unit

This block adds or subtracts two 64-bit operands as a set of independent integer lanes. The lanes are 8, 16, 32 or 64 bits wide, and a carry or borrow never passes from one lane into the next. Each lane follows one of three overflow policies: plain wraparound, unsigned clamping or signed clamping. A scalar option computes lane 0 only. In that case every higher lane takes its bits from the incoming destination value, so a scalar operation leaves the upper part of a register unchanged.

The caller presents both operands, the current destination value and the operation controls, and raises `in_valid` for one cycle. The packed result and `out_valid` appear on the next clock edge. The result register keeps its value until the next accepted operation.

Top module: `packed_satadd`

## Requirements
- R1: `out_valid` is high in exactly those cycles that follow a cycle with `in_valid` high. While `rst_n` is low at a clock edge, `out_valid` and `result` are cleared to zero.
- R2: `lane_size` selects the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. With `op_usat` and `op_ssat` both low, each lane wraps modulo 2^width and no carry crosses a lane boundary.
- R3: When `op_usat` is high and `op_sub` is low, a lane whose sum carries out of the lane yields all ones.
- R4: When `op_usat` is high and `op_sub` is high, a lane yields zero if its `src_b` value is greater than its `src_a` value as an unsigned number. Otherwise the lane yields the difference.
- R5: When `op_ssat` is high, `op_usat` is low and `op_sub` is low, a lane overflows when both operand signs are equal and the sign of the wrapped result differs from them. An overflowed lane whose result sign bit is 0 yields the most negative value (top bit 1, all other bits 0). An overflowed lane whose result sign bit is 1 yields the most positive value (top bit 0, all other bits 1).
- R6: Signed subtract follows R5 with the sign of `src_b` inverted, so it overflows when the operand signs differ and the result sign differs from the sign of `src_a`.
- R7: With both `op_usat` and `op_ssat` high, every lane follows the unsigned rules of R3 and R4.
- R8: When `op_scalar` is high, only lane 0 is computed. Every other lane of `result` equals the same bits of `dst_in`.
- R9: `result` holds its value in every cycle that follows a cycle with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| src_a | input | 64 | First operand (minuend for subtract) |
| src_b | input | 64 | Second operand (subtrahend for subtract) |
| dst_in | input | 64 | Current destination value, used for the lanes kept in scalar mode |
| op_sub | input | 1 | 1 selects subtract, 0 selects add |
| lane_size | input | 2 | Lane width code (see R2) |
| op_scalar | input | 1 | Compute lane 0 only |
| op_usat | input | 1 | Unsigned saturation |
| op_ssat | input | 1 | Signed saturation |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Registered packed result |

## Verification
A wrong lane decision shows up in `result` on the cycle right after the strobe. A misrouted width-select or a carry that leaks between lanes corrupts the lane just above the boundary. The 8-bit width is swept over every operand pair, in every policy and for both add and subtract. The wider lanes are driven with random values mixed with boundary values near zero and near the signed extremes. A wrong hold or valid path shows as a result that changes, or a strobe that stays high, in an idle cycle.

// File: rtl/psat_pkg.sv
// Shared definitions for the packed saturating add/subtract unit.
// Assumes a datapath that is a multiple of 64 bits wide.
package psat_pkg;
    localparam int NUM_SIZES = 4;
    localparam int BASE_W    = 8;

    // Lane width in bits for a given size code (0..3 -> 8..64)
    function automatic int lane_width(input int code);
        return BASE_W << code;
    endfunction
endpackage

// File: rtl/psat_lane.sv
// One arithmetic lane: add or subtract with wrap, unsigned clamp or
// signed clamp. Purely combinational. Assumes W >= 2.
module psat_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         usat_i,
    input  logic         ssat_i,
    output logic [W-1:0] r_o
);
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0]   add_ext;
    logic [W-1:0] raw;
    logic         b_sign_eff;
    logic         sovf;
    logic         borrow;

    // Raw wrapped result plus the overflow indications for both policies
    always_comb begin
        add_ext    = {1'b0, a_i} + {1'b0, b_i};
        raw        = sub_i ? (a_i - b_i) : add_ext[W-1:0];
        borrow     = b_i > a_i;
        b_sign_eff = b_i[W-1] ^ sub_i;
        sovf       = (a_i[W-1] == b_sign_eff) && (raw[W-1] != a_i[W-1]);
    end

    // Apply the clamping policy, unsigned taking priority
    always_comb begin
        r_o = raw;
        if (usat_i) begin
            if (!sub_i && add_ext[W]) r_o = '1;
            else if (sub_i && borrow) r_o = '0;
        end else if (ssat_i && sovf) begin
            r_o = raw[W-1] ? POS_MAX : NEG_MIN;
        end
    end

    // Invariants of the clamped result relative to the operands
    always_comb begin
        if (!$isunknown({a_i, b_i, sub_i, usat_i, ssat_i})) begin
            if (usat_i && !sub_i)
                assert_usat_add_floor_R3: assert (r_o >= a_i);
            if (usat_i && sub_i)
                assert_usat_sub_ceiling_R4: assert (r_o <= a_i);
            if (ssat_i && !usat_i && !sub_i && (a_i[W-1] == b_i[W-1]))
                assert_ssat_sign_kept_R5: assert (r_o[W-1] == a_i[W-1]);
        end
    end
endmodule

// File: rtl/psat_width_unit.sv
// All lanes of one width across the datapath. In scalar mode every lane
// above lane 0 passes the destination bits through.
// Assumes DATA_W is a multiple of W.
module psat_width_unit #(
    parameter int DATA_W = 64,
    parameter int W      = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic              sub_i,
    input  logic              usat_i,
    input  logic              ssat_i,
    input  logic              scalar_i,
    output logic [DATA_W-1:0] r_o
);
    localparam int LANES = DATA_W / W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [W-1:0] lane_r;

        psat_lane #(.W(W)) u_lane (
            .a_i    (a_i[i*W +: W]),
            .b_i    (b_i[i*W +: W]),
            .sub_i  (sub_i),
            .usat_i (usat_i),
            .ssat_i (ssat_i),
            .r_o    (lane_r)
        );

        if (i == 0) begin : g_low
            // Lane 0 is always computed
            assign r_o[i*W +: W] = lane_r;
        end else begin : g_high
            // Upper lanes keep the destination in scalar mode
            assign r_o[i*W +: W] = scalar_i ? dst_i[i*W +: W] : lane_r;
        end
    end
endmodule

// File: rtl/packed_satadd.sv
// Packed integer add/subtract with per-lane overflow policy and a
// registered result. Builds one lane array per width and selects one.
// Assumes DATA_W is a multiple of the widest lane (64).
module packed_satadd #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] dst_in,
    input  logic              op_sub,
    input  logic [1:0]        lane_size,
    input  logic              op_scalar,
    input  logic              op_usat,
    input  logic              op_ssat,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    import psat_pkg::*;

    logic [DATA_W-1:0] width_res [NUM_SIZES];
    logic [DATA_W-1:0] next_res;

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_width
        psat_width_unit #(.DATA_W(DATA_W), .W(lane_width(k))) u_unit (
            .a_i      (src_a),
            .b_i      (src_b),
            .dst_i    (dst_in),
            .sub_i    (op_sub),
            .usat_i   (op_usat),
            .ssat_i   (op_ssat),
            .scalar_i (op_scalar),
            .r_o      (width_res[k])
        );
    end

    // Pick the lane array matching the requested width
    always_comb next_res = width_res[lane_size];

    // Register the result and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_res;
        end
    end

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    assert_scalar_keeps_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_scalar && lane_size == 2'd0)
        |=> result[DATA_W-1:8] == $past(dst_in[DATA_W-1:8]));
endmodule

// File: tb/packed_satadd_tb.sv
module packed_satadd_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] src_a = '0, src_b = '0, dst_in = '0;
    logic        op_sub = 1'b0, op_scalar = 1'b0, op_usat = 1'b0, op_ssat = 1'b0;
    logic [1:0]  lane_size = 2'd0;
    logic        out_valid;
    logic [63:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    packed_satadd u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .dst_in(dst_in),
        .op_sub(op_sub), .lane_size(lane_size), .op_scalar(op_scalar),
        .op_usat(op_usat), .op_ssat(op_ssat),
        .out_valid(out_valid), .result(result)
    );

    // Watchdog: an expired run counts as a failure
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got cycle %0d exp < 190000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Arithmetic model built from the requirements
    function automatic logic [63:0] model(input logic [63:0] a, b, d,
                                          input logic sub, input logic [1:0] sz,
                                          input logic sc, us, ss);
        int w, n;
        logic [64:0] m, x, y, s, r;
        logic [63:0] res;
        w = 8 << sz;
        n = sc ? 1 : 64 / w;
        m = (65'd1 << w) - 65'd1;
        res = d;
        for (int i = 0; i < n; i++) begin
            x = ({1'b0, a} >> (i * w)) & m;
            y = ({1'b0, b} >> (i * w)) & m;
            if (!sub) begin
                s = x + y;
                r = s & m;
                if (us) begin
                    if (s > m) r = m;
                end else if (ss) begin
                    if (x[w-1] == y[w-1] && r[w-1] != x[w-1])
                        r = r[w-1] ? (m >> 1) : ((m >> 1) + 65'd1);
                end
            end else begin
                r = (x - y) & m;
                if (us) begin
                    if (y > x) r = '0;
                end else if (ss) begin
                    if (x[w-1] != y[w-1] && r[w-1] != x[w-1])
                        r = r[w-1] ? (m >> 1) : ((m >> 1) + 65'd1);
                end
            end
            for (int j = 0; j < w; j++) res[i*w + j] = r[j];
        end
        return res;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic string tag_of(input logic sub, sc, us, ss);
        if (sc) return "R8";
        if (us && ss) return "R7";
        if (us) return sub ? "R4" : "R3";
        if (ss) return sub ? "R6" : "R5";
        return "R2";
    endfunction

    // Drive one operation at a falling edge, check at the next falling edge
    task automatic run_op(input logic [63:0] a, b, d, input logic sub,
                          input logic [1:0] sz, input logic sc, us, ss);
        logic [63:0] exp;
        src_a = a; src_b = b; dst_in = d; op_sub = sub; lane_size = sz;
        op_scalar = sc; op_usat = us; op_ssat = ss; in_valid = 1'b1;
        exp = model(a, b, d, sub, sz, sc, us, ss);
        @(negedge clk);
        check(out_valid === 1'b1 && result === exp, tag_of(sub, sc, us, ss),
              result, exp);
    endtask

    function automatic logic [63:0] edge_val(input int sel, input logic [1:0] sz);
        int w;
        logic [63:0] v;
        w = 8 << sz;
        v = '0;
        case (sel % 6)
            0: v = '0;
            1: v = 64'd1;
            2: for (int j = 0; j < w - 1; j++) v[j] = 1'b1;
            3: v[w-1] = 1'b1;
            4: v = '1;
            default: v = {$urandom, $urandom};
        endcase
        for (int i = 1; i < 64 / w; i++)
            for (int j = 0; j < w; j++) v[i*w + j] = v[j] ^ logic'((i + j + sel) % 3 == 0);
        return v;
    endfunction

    initial begin
        logic [63:0] held, bv;

        // Reset state (R1)
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1 reset valid", {63'd0, out_valid}, 64'd0);
        check(result === 64'd0, "R1 reset result", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R1 idle after reset", {63'd0, out_valid}, 64'd0);

        // Exhaustive 8-bit lanes: every operand pair, all policies, both ops
        for (int md = 0; md < 4; md++) begin
            for (int sb = 0; sb < 2; sb++) begin
                for (int a = 0; a < 256; a++) begin
                    for (int g = 0; g < 32; g++) begin
                        for (int j = 0; j < 8; j++) bv[j*8 +: 8] = 8'(g * 8 + j);
                        run_op({8{8'(a)}}, bv, {$urandom, $urandom}, sb[0], 2'd0,
                               1'b0, md[0], md[1]);
                    end
                end
            end
        end

        // Wider lanes: boundary mixes and random values
        for (int sz = 1; sz < 4; sz++)
            for (int md = 0; md < 4; md++)
                for (int sb = 0; sb < 2; sb++)
                    for (int k = 0; k < 200; k++)
                        run_op(edge_val(k, 2'(sz)), edge_val(k / 6 + k, 2'(sz)),
                               {$urandom, $urandom}, sb[0], 2'(sz), 1'b0, md[0], md[1]);

        // Scalar mode on every width (R8)
        for (int sz = 0; sz < 4; sz++)
            for (int md = 0; md < 4; md++)
                for (int k = 0; k < 40; k++)
                    run_op(edge_val(k, 2'(sz)), edge_val(k + 3, 2'(sz)),
                           {$urandom, $urandom}, k[0], 2'(sz), 1'b1, md[0], md[1]);

        // Idle cycles: valid drops and the result holds (R1, R9)
        for (int k = 0; k < 8; k++) begin
            held = result;
            in_valid = 1'b0;
            src_a = {$urandom, $urandom}; src_b = {$urandom, $urandom};
            @(negedge clk);
            check(out_valid === 1'b0, "R1 idle valid", {63'd0, out_valid}, 64'd0);
            check(result === held, "R9 hold", result, held);
            run_op({$urandom, $urandom}, {$urandom, $urandom}, '0, 1'b0, 2'(k % 4),
                   1'b0, 1'b0, 1'b0);
        end
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule